// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block turns single internal read or write requests into accesses on an external bus whose 16 data pins also carry the low address bits. Four chip-select regions share these pins. Each region has its own timing word. The word places every strobe edge as a count of fast memory-clock ticks. The controller runs on the memory clock. It tracks the phase of a slower system clock, whose frequency is 1, 2 or 4 times lower, and it starts every access on a system-clock rising edge plus a per-region offset.

An access first drives the address on the shared pins and the upper address lines. At a programmed tick the shared pins switch to the data phase. In that phase the upper lines go to zero, and the pins either carry write data or are released so that read data can be sampled. Wait states are fixed: the access always ends at the region's programmed end tick. The controller reports `busy` while it holds a request. At the end of every access it raises `done` for one clock, together with the captured read data.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset every chip select, `as_n`, `re_n` and `we_n` is high, `ad_oe`, `busy` and `done` are low, and `addr_hi` is zero.
- R2: Region r's timing word is `timing_cfg[28r+27:28r]`. Its nibbles, from the least significant, are: start offset, strobe-on, strobe-off, switch point, read-on, write-on, end. A request sampled at a clock edge waits for the next memory cycle that is a system-clock phase-zero cycle (cycle k). The access then occupies the cycles k+1+start through k+start+E, where E is the effective end.
- R3: `ratio_sel` 0, 1 and 2 select memory/system ratios of 1, 2 and 4. Code 3 behaves like code 2. The system-clock phase counter is zero in the first cycle after reset.
- R4: During an access only the chip select of the requested region is low, and it stays low for exactly E cycles. No chip select is low outside an access.
- R5: With t the tick count from the access start (0 at the first access cycle), `as_n` is low exactly when strobe-on ≤ t < strobe-off.
- R6: `ad_out` carries address bits 15:0 with `ad_oe` high while t < switch point. From the switch point onward `ad_oe` is high with `ad_out` equal to the write data for a write, and low for a read. `ad_oe` is low whenever no chip select is low.
- R7: `addr_hi` carries address bits 23:16 while t < switch point, and it is zero in the data phase and between accesses.
- R8: For a write, `we_n[0]` (data on `ad_out[7:0]`) is low when `req_be[0]` was set, and `we_n[1]` (data on `ad_out[15:8]`) is low when `req_be[1]` was set, each for t ≥ write-on. Neither is low during a read.
- R9: For a read, `re_n` is low for t ≥ read-on. `ad_in` is sampled at the edge that ends the access. In the following cycle `done` is high for one cycle and `rd_data` holds the sample. Writes also raise `done`.
- R10: `busy` is high from the cycle after acceptance through the last access cycle. A request presented while `busy` is high is ignored.
- R11: An end field below 2 gives an effective end E of 2. Otherwise E equals the end field.
- R12: `ad_pull` equals `pull_sel` outside an access and is low during an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock (fast clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Memory/system clock ratio code, changed only in reset |
| timing_cfg | input | 112 | Four 28-bit region timing words |
| pull_sel | input | 1 | Pull-up choice for the shared pins when not driven by an access |
| req | input | 1 | Access request |
| req_region | input | 2 | Target region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte lanes to write |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request held or access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 16 | Captured read data |
| ad_in | input | 16 | Shared pins, input side |
| ad_out | output | 16 | Shared pins, output side |
| ad_oe | output | 1 | Output enable for the shared pins |
| addr_hi | output | 8 | Upper address lines 23:16 |
| cs_n | output | 4 | Active-low region chip selects |
| as_n | output | 1 | Active-low address strobe |
| re_n | output | 1 | Active-low read enable |
| we_n | output | 2 | Active-low per-byte write enables |
| ad_pull | output | 1 | Pull-up enable for the shared pins |

## Verification
The bench drives requests that land on every system-clock phase at ratios 1, 2 and 4, and with ratio code 3. A design that ignored the phase, or that counted the start offset from acceptance, would move every chip-select edge. Region 3 uses an end field of 1. A design that did not clamp it would give a one-tick access or count forever. Back-to-back requests arrive in the very cycle `done` rises, which exposes an off-by-one in `busy`. Requests sent during a long access must leave the access unchanged. The byte-lane writes and the read sample at the ending edge catch swapped write enables and data captured one tick early.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam int FIELD_W = 4;

  // Edge plan of one region; start_pt sits in the low nibble.
  typedef struct packed {
    logic [FIELD_W-1:0] end_pt;
    logic [FIELD_W-1:0] we_on;
    logic [FIELD_W-1:0] re_on;
    logic [FIELD_W-1:0] switch_pt;
    logic [FIELD_W-1:0] as_off;
    logic [FIELD_W-1:0] as_on;
    logic [FIELD_W-1:0] start_pt;
  } edge_plan_t;

  localparam int PLAN_W = $bits(edge_plan_t);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_DELAY,
    ST_ACCESS
  } seq_state_t;

  // Memory-clock ticks per system-clock period for a ratio code.
  function automatic int unsigned ratio_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Access length after clamping to the minimum.
  function automatic logic [FIELD_W-1:0] effective_end(
      input logic [FIELD_W-1:0] end_field, input int unsigned min_len);
    if (int'(end_field) < int'(min_len)) return FIELD_W'(min_len);
    return end_field;
  endfunction

  // Half-open window test lo <= t < hi.
  function automatic logic in_window(input logic [FIELD_W-1:0] t,
                                     input logic [FIELD_W-1:0] lo,
                                     input logic [FIELD_W-1:0] hi);
    return (t >= lo) && (t < hi);
  endfunction

endpackage

// File: rtl/mbc_phase_gen.sv
module mbc_phase_gen
  import mbc_pkg::*;
#(
  parameter int MAX_RATIO = 4,
  parameter int PH_W      = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  output logic       slow_edge
);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] phase_last;

  assign phase_last = PH_W'(ratio_ticks(ratio_sel) - 1);
  assign slow_edge  = (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (phase >= phase_last) phase <= '0;
    else phase <= phase + 1'b1;
  end

  // R3: phase never leaves the range of the selected ratio
  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < int'(ratio_ticks(ratio_sel)));

endmodule

// File: rtl/mbc_sequencer.sv
module mbc_sequencer
  import mbc_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 2,
  parameter int REG_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  parameter int LANES   = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slow_edge,
  input  logic [NUM_REG*PLAN_W-1:0] timing_cfg,
  input  logic                      req,
  input  logic [REG_W-1:0]          req_region,
  input  logic                      req_write,
  input  logic [LANES-1:0]          req_be,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [DATA_W-1:0]         ad_in,
  output logic                      in_access,
  output logic [FIELD_W-1:0]        tick,
  output edge_plan_t                plan,
  output logic [REG_W-1:0]          region,
  output logic                      wr,
  output logic [LANES-1:0]          be,
  output logic [ADDR_W-1:0]         addr,
  output logic [DATA_W-1:0]         wdata,
  output logic                      busy,
  output logic                      done,
  output logic [DATA_W-1:0]         rd_data
);

  edge_plan_t         plans [NUM_REG];
  seq_state_t         state;
  logic [FIELD_W-1:0] eff_end;
  logic               last_tick;
  logic               start_now;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_unpack
    assign plans[g] = edge_plan_t'(timing_cfg[g*PLAN_W +: PLAN_W]);
  end

  assign eff_end   = effective_end(plan.end_pt, MIN_LEN);
  assign last_tick = (state == ST_ACCESS) && (tick == eff_end - 1'b1);
  assign in_access = (state == ST_ACCESS);
  assign busy      = (state != ST_IDLE);
  assign start_now = ((state == ST_ALIGN) && slow_edge && (plan.start_pt == '0)) ||
                     ((state == ST_DELAY) && (tick == plan.start_pt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tick    <= '0;
      plan    <= '0;
      region  <= '0;
      wr      <= 1'b0;
      be      <= '0;
      addr    <= '0;
      wdata   <= '0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            plan   <= plans[req_region];
            region <= req_region;
            wr     <= req_write;
            be     <= req_be;
            addr   <= req_addr;
            wdata  <= req_wdata;
            state  <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (start_now) begin
            tick  <= '0;
            state <= ST_ACCESS;
          end else if (slow_edge) begin
            tick  <= FIELD_W'(1);
            state <= ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (start_now) begin
            tick  <= '0;
            state <= ST_ACCESS;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          if (last_tick) begin
            tick  <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
            if (!wr) rd_data <= ad_in;
          end else begin
            tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end

  // R2: an access entered from alignment always follows a system-clock phase zero
  assert_align_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access && $past(state) == ST_ALIGN) |-> $past(slow_edge));

  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: read data equals the pins at the ending edge
  assert_read_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr) |-> (rd_data == $past(ad_in)));

  // R10: busy only rises after a request
  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  // R11: the tick count never reaches the effective end inside an access
  assert_tick_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_access |-> (tick < eff_end));

endmodule

// File: rtl/mbc_pin_drive.sv
module mbc_pin_drive
  import mbc_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int REG_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  parameter int LANES   = DATA_W / 8
) (
  input  logic                 in_access,
  input  logic [FIELD_W-1:0]   tick,
  input  edge_plan_t           plan,
  input  logic [REG_W-1:0]     region,
  input  logic                 wr,
  input  logic [LANES-1:0]     be,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 pull_sel,
  output logic                 data_phase,
  output logic [DATA_W-1:0]    ad_out,
  output logic                 ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [NUM_REG-1:0]   cs_n,
  output logic                 as_n,
  output logic                 re_n,
  output logic [LANES-1:0]     we_n,
  output logic                 ad_pull
);

  logic addr_phase;
  logic read_on;
  logic write_on;

  assign data_phase = in_access && (tick >= plan.switch_pt);
  assign addr_phase = in_access && !data_phase;
  assign read_on    = in_access && !wr && (tick >= plan.re_on);
  assign write_on   = in_access && wr && (tick >= plan.we_on);

  assign as_n    = !(in_access && in_window(tick, plan.as_on, plan.as_off));
  assign re_n    = !read_on;
  assign ad_oe   = addr_phase || (data_phase && wr);
  assign addr_hi = addr_phase ? addr[ADDR_W-1:DATA_W] : '0;
  assign ad_pull = pull_sel && !in_access;

  always_comb begin
    if (addr_phase)             ad_out = addr[DATA_W-1:0];
    else if (data_phase && wr)  ad_out = wdata;
    else                        ad_out = '0;
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_cs
    assign cs_n[g] = !(in_access && (region == REG_W'(g)));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we_n[g] = !(write_on && be[g]);
  end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int NUM_REG   = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int MIN_LEN   = 2,
  parameter int MAX_RATIO = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       ratio_sel,
  input  logic [NUM_REG*PLAN_W-1:0]        timing_cfg,
  input  logic                             pull_sel,
  input  logic                             req,
  input  logic [$clog2(NUM_REG)-1:0]       req_region,
  input  logic                             req_write,
  input  logic [DATA_W/8-1:0]              req_be,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [DATA_W-1:0]                req_wdata,
  output logic                             busy,
  output logic                             done,
  output logic [DATA_W-1:0]                rd_data,
  input  logic [DATA_W-1:0]                ad_in,
  output logic [DATA_W-1:0]                ad_out,
  output logic                             ad_oe,
  output logic [ADDR_W-DATA_W-1:0]         addr_hi,
  output logic [NUM_REG-1:0]               cs_n,
  output logic                             as_n,
  output logic                             re_n,
  output logic [DATA_W/8-1:0]              we_n,
  output logic                             ad_pull
);

  localparam int REG_W = $clog2(NUM_REG);
  localparam int LANES = DATA_W / 8;

  logic               slow_edge;
  logic               in_access;
  logic [FIELD_W-1:0] tick;
  edge_plan_t         plan;
  logic [REG_W-1:0]   region;
  logic               wr;
  logic [LANES-1:0]   be;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  wdata;
  logic               data_phase;
  logic               cs_any;

  mbc_phase_gen #(.MAX_RATIO(MAX_RATIO)) i_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .slow_edge (slow_edge)
  );

  mbc_sequencer #(
    .NUM_REG (NUM_REG), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .MIN_LEN (MIN_LEN), .REG_W (REG_W), .LANES (LANES)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_edge  (slow_edge),
    .timing_cfg (timing_cfg),
    .req        (req),
    .req_region (req_region),
    .req_write  (req_write),
    .req_be     (req_be),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ad_in      (ad_in),
    .in_access  (in_access),
    .tick       (tick),
    .plan       (plan),
    .region     (region),
    .wr         (wr),
    .be         (be),
    .addr       (addr),
    .wdata      (wdata),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data)
  );

  mbc_pin_drive #(
    .NUM_REG (NUM_REG), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .REG_W (REG_W), .LANES (LANES)
  ) i_pins (
    .in_access  (in_access),
    .tick       (tick),
    .plan       (plan),
    .region     (region),
    .wr         (wr),
    .be         (be),
    .addr       (addr),
    .wdata      (wdata),
    .pull_sel   (pull_sel),
    .data_phase (data_phase),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .addr_hi    (addr_hi),
    .cs_n       (cs_n),
    .as_n       (as_n),
    .re_n       (re_n),
    .we_n       (we_n),
    .ad_pull    (ad_pull)
  );

  assign cs_any = !(&cs_n);

  // R4: at most one region selected
  assert_one_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R6: pins released whenever no region is selected
  assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_any |-> !ad_oe);

  // R7: upper lines are zero during the data phase
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> (addr_hi == '0));

  // R8: read and write enables never overlap
  assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!re_n && !(&we_n)));

  // R10: busy covers the whole access
  assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_any |-> busy);

  // R12: pull-up is never requested while the pins are driven
  assert_pull_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !ad_pull);

endmodule

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/1ps
module test_mux_bus_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   ratio_sel = 2'd2;
  logic [111:0] timing_cfg = '0;
  logic         pull_sel = 1'b0;
  logic         req = 1'b0;
  logic [1:0]   req_region = '0;
  logic         req_write = 1'b0;
  logic [1:0]   req_be = '0;
  logic [23:0]  req_addr = '0;
  logic [15:0]  req_wdata = '0;
  logic         busy, done;
  logic [15:0]  rd_data;
  logic [15:0]  ad_in = '0;
  logic [15:0]  ad_out;
  logic         ad_oe;
  logic [7:0]   addr_hi;
  logic [3:0]   cs_n;
  logic         as_n, re_n, ad_pull;
  logic [1:0]   we_n;

  always #4 clk = ~clk;

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .timing_cfg(timing_cfg),
    .pull_sel(pull_sel), .req(req), .req_region(req_region), .req_write(req_write),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .done(done), .rd_data(rd_data), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .cs_n(cs_n), .as_n(as_n), .re_n(re_n), .we_n(we_n),
    .ad_pull(ad_pull)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ratio = 4;
  bit finished = 0;

  // per-region timing fields: start, strobe on/off, switch, read-on, write-on, end
  int f_st[4], f_aon[4], f_aoff[4], f_sw[4], f_ron[4], f_won[4], f_end[4];

  // reference model job
  bit          job = 0;
  int          j_acc, j_start, j_stop, j_reg;
  int          j_aon, j_aoff, j_sw, j_ron, j_won;
  bit          j_wr;
  logic [1:0]  j_be;
  logic [23:0] j_addr;
  logic [15:0] j_wd;
  int          dq_at[$];
  bit          dq_rd[$];

  function automatic logic [15:0] pat(int m);
    return 16'(m * 947) ^ 16'hC35A;
  endfunction

  function automatic void load_cfg();
    for (int r = 0; r < 4; r++) begin
      timing_cfg[28*r +: 28] = {4'(f_end[r]), 4'(f_won[r]), 4'(f_ron[r]), 4'(f_sw[r]),
                                4'(f_aoff[r]), 4'(f_aon[r]), 4'(f_st[r])};
    end
  endfunction

  function automatic bit model_busy(int n);
    return job && (n >= j_acc + 1) && (n < j_stop);
  endfunction

  function automatic void schedule(int n);
    int k;
    int len;
    k = n + 1;
    while (k % ratio != 0) k++;
    len = (f_end[req_region] < 2) ? 2 : f_end[req_region];  // R11 clamp
    job = 1; j_acc = n; j_reg = req_region;
    j_start = k + 1 + f_st[req_region];
    j_stop = j_start + len;
    j_aon = f_aon[req_region]; j_aoff = f_aoff[req_region]; j_sw = f_sw[req_region];
    j_ron = f_ron[req_region]; j_won = f_won[req_region];
    j_wr = req_write; j_be = req_be; j_addr = req_addr; j_wd = req_wdata;
    dq_at.push_back(j_stop);
    dq_rd.push_back(!req_write);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d ratio %0d: actual %h expected %h", tag, cyc, ratio, act, exp);
    end
  endtask

  task automatic compare();
    int n;
    int t;
    bit act;
    bit dp;
    logic [3:0] e_cs;
    logic [1:0] e_we;
    bit e_as, e_re, e_oe, e_done;
    logic [15:0] e_ad;
    logic [7:0] e_hi;
    n = cyc;
    act = job && (n >= j_start) && (n < j_stop);
    t = n - j_start;
    e_cs = 4'hF; e_we = 2'b11; e_as = 1; e_re = 1; e_oe = 0; e_ad = '0; e_hi = '0;
    if (act) begin
      dp = (t >= j_sw);
      e_cs[j_reg] = 1'b0;
      e_as = !(t >= j_aon && t < j_aoff);
      e_oe = !dp || j_wr;
      e_ad = dp ? j_wd : j_addr[15:0];
      e_hi = dp ? 8'h00 : j_addr[23:16];
      e_re = !(!j_wr && t >= j_ron);
      for (int b = 0; b < 2; b++) e_we[b] = !(j_wr && t >= j_won && j_be[b]);
    end
    chk("R4 chip select (R2 R3 R11 timing)", 32'(cs_n), 32'(e_cs));
    chk("R5 address strobe", 32'(as_n), 32'(e_as));
    chk("R6 pin enable", 32'(ad_oe), 32'(e_oe));
    if (e_oe) chk("R6 pin value", 32'(ad_out), 32'(e_ad));
    chk("R7 upper address", 32'(addr_hi), 32'(e_hi));
    chk("R8 write enables", 32'(we_n), 32'(e_we));
    chk("R9 read enable", 32'(re_n), 32'(e_re));
    chk("R10 busy", 32'(busy), 32'(model_busy(n)));
    chk("R12 pull", 32'(ad_pull), 32'(pull_sel && !act));
    e_done = 0;
    if (dq_at.size() > 0 && dq_at[0] == n) begin
      e_done = 1;
      if (dq_rd[0]) chk("R9 read data", 32'(rd_data), 32'(pat(n - 1)));
      void'(dq_at.pop_front());
      void'(dq_rd.pop_front());
    end
    chk("R9 done pulse", 32'(done), 32'(e_done));
  endtask

  task automatic tick();
    if (req && !model_busy(cyc)) schedule(cyc);
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compare();
    ad_in = pat(cyc);
  endtask

  task automatic apply_reset(logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    req = 1'b0;
    ratio_sel = code;
    ratio = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;  // R3 code map
    job = 0;
    dq_at.delete();
    dq_rd.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    ad_in = pat(0);
    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 strobes", 32'({as_n, re_n, we_n}), 32'hF);
    chk("R1 flags", 32'({ad_oe, busy, done}), 32'h0);
    chk("R1 upper", 32'(addr_hi), 32'h0);
  endtask

  task automatic issue(int r, bit w, logic [1:0] b, logic [23:0] a, logic [15:0] d);
    while (model_busy(cyc)) tick();
    req = 1'b1; req_region = 2'(r); req_write = w; req_be = b;
    req_addr = a; req_wdata = d;
    tick();
    req = 1'b0;
  endtask

  task automatic suite(int salt);
    pull_sel = 1'b0;
    issue(0, 0, 2'b00, 24'hA51234 + 24'(salt), 16'h0);       // R9 read
    issue(1, 1, 2'b11, 24'h3C0F0F, 16'hBEEF ^ 16'(salt));     // R8 both lanes
    issue(2, 1, 2'b01, 24'h7E0002, 16'h1122);                 // R8 low lane, start 5 (R2)
    issue(3, 1, 2'b10, 24'h810003, 16'h3344);                 // R11 end 1, high lane
    issue(3, 0, 2'b00, 24'hFF0004, 16'h0);                    // R11 read
    repeat (salt % 3) tick();
    pull_sel = 1'b1;                                          // R12
    issue(0, 1, 2'b11, 24'h123456, 16'h5566);
    // R10: requests during a long access are ignored
    issue(2, 0, 2'b00, 24'h0F0F0F, 16'h0);
    repeat (3) tick();
    req = 1'b1; req_region = 2'd1; req_write = 1'b1; req_be = 2'b11;
    req_addr = 24'hDEAD00; req_wdata = 16'hFFFF;
    repeat (2) tick();
    req = 1'b0;
    issue(1, 0, 2'b00, 24'h00AA55, 16'h0);
    pull_sel = 1'b0;
    repeat (24) tick();
  endtask

  initial begin
    f_st = '{1, 0, 5, 2}; f_aon = '{0, 0, 1, 0}; f_aoff = '{2, 1, 3, 1};
    f_sw = '{3, 2, 4, 1}; f_ron = '{4, 2, 5, 1}; f_won = '{4, 3, 5, 1};
    f_end = '{8, 6, 10, 1};
    load_cfg();
    apply_reset(2'd2); suite(0);   // R3 ratio 4
    apply_reset(2'd1); suite(1);   // R3 ratio 2
    apply_reset(2'd0); suite(2);   // R3 ratio 1
    f_end[3] = 0; f_st[0] = 3; load_cfg();
    apply_reset(2'd3); suite(4);   // R3 code 3 acts as ratio 4, R11 end 0
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule